// File: doc/BRIEF.md
# Dual Rail Reset Supervisor with Windowed Watchdog

This block supervises a system powered from two supply rails and watched over by a processor. Each rail has a "rail good" input that is already synchronous to the block clock. While the block is enabled, each rail's active-low reset output stays asserted until that rail has been good for a programmable number of clock cycles. The two rails are timed independently.

Once both rail resets are released, the block waits through a start-up delay. It then checks the processor's watchdog input. Only falling edges on that input count as activity, and each one must arrive inside a window measured from the previous edge: not earlier than a minimum count and not later than a maximum count. An edge outside that window drives the active-low watchdog output low for one reset timeout. When the output is released, monitoring resumes only after a fresh start-up delay. All timings are clock-cycle parameters, and the watchdog input passes through a two-flop synchronizer.

Top module: `dual_rail_supervisor`

## Requirements
- R1: After the synchronous reset `rst`, and for as long as `enable` is low, both rail reset outputs are low and `wd_fault_n` is high.
- R2: `rst_a_n` goes high at the clock edge on which `enable` and `rail_a_good` have been sampled high on RESET_CYCLES consecutive edges. It then stays high while both remain high.
- R3: `rst_b_n` follows the same rule as R2 using `rail_b_good`, independently of rail A.
- R4: The start-up delay begins only when both rail resets are high and lasts DELAY_CYCLES edges. Watchdog input activity during the delay has no effect on `wd_fault_n`.
- R5: `wd_in` passes through two synchronizer flops. A high-to-low transition of the synchronized value is the only activity the watchdog counts, and rising transitions are ignored.
- R6: A counted falling edge that arrives while the window count is below WIN_MIN is an early fault. `wd_fault_n` goes low at the next edge.
- R7: If no falling edge is counted before the window count reaches WIN_MAX, it is a late fault and `wd_fault_n` goes low.
- R8: A falling edge counted at a window count of at least WIN_MIN is accepted and restarts the window count from zero.
- R9: After a fault, `wd_fault_n` stays low for exactly RESET_CYCLES edges. It then goes high, and a full start-up delay runs before the window is checked again.
- R10: If `enable` goes low or a rail good input drops, the affected reset output goes low at the next edge. The watchdog returns to idle with `wd_fault_n` high until both resets are released again.
- R11: `wd_fault_n` is low only during a watchdog fault timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global enable; low holds both rail resets asserted |
| rail_a_good | input | 1 | Rail A within regulation (synchronous) |
| rail_b_good | input | 1 | Rail B within regulation (synchronous) |
| wd_in | input | 1 | Processor watchdog kick, asynchronous |
| rst_a_n | output | 1 | Rail A reset, active low |
| rst_b_n | output | 1 | Rail B reset, active low |
| wd_fault_n | output | 1 | Watchdog fault, active low |

## Verification
The rails come up staggered, so the per-rail timers and the gating of the start-up delay can be told apart. Watchdog pulses are given during the delay and then at a steady spacing inside the window, which separates counted activity from ignored activity. A too-early pulse and a missing pulse each exercise one fault path, followed by the fault timeout and the fresh delay. Dropping one rail mid-window and finally removing the enable show whether the supervisor falls back to idle correctly.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_DELAY  = 2'd1,
        WD_WINDOW = 2'd2,
        WD_FAULT  = 2'd3
    } wd_state_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_bits(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sup_rail_timer.sv
module sup_rail_timer #(
    parameter int unsigned RESET_CYCLES = 20,
    parameter int unsigned CW           = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic qualify,
    output logic released
);
    localparam logic [CW-1:0] LAST = CW'(RESET_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !qualify) begin
            cnt      <= '0;
            released <= 1'b0;
        end else if (!released) begin
            if (cnt == LAST) begin
                released <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sup_edge_sync.sv
module sup_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], din};
        end
    end

    assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
    import sup_pkg::*;
#(
    parameter int unsigned RESET_CYCLES = 20,
    parameter int unsigned DELAY_CYCLES = 15,
    parameter int unsigned WIN_MIN      = 8,
    parameter int unsigned WIN_MAX      = 30,
    parameter int unsigned CW           = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic supervise,
    input  logic fall,
    output logic fault_n
);
    localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_CYCLES - 1);
    localparam logic [CW-1:0] RST_LAST = CW'(RESET_CYCLES - 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(WIN_MAX - 1);
    localparam logic [CW-1:0] WIN_LO   = CW'(WIN_MIN);

    typedef struct packed {
        wd_state_e     state;
        logic [CW-1:0] cnt;
    } wd_ctx_t;

    wd_ctx_t ctx, ctx_nx;

    always_comb begin
        ctx_nx = ctx;
        if (!supervise) begin
            ctx_nx.state = WD_IDLE;
            ctx_nx.cnt   = '0;
        end else begin
            unique case (ctx.state)
                WD_IDLE: begin
                    ctx_nx.state = WD_DELAY;
                    ctx_nx.cnt   = '0;
                end
                WD_DELAY: begin
                    if (ctx.cnt == DLY_LAST) begin
                        ctx_nx.state = WD_WINDOW;
                        ctx_nx.cnt   = '0;
                    end else begin
                        ctx_nx.cnt = ctx.cnt + 1'b1;
                    end
                end
                WD_WINDOW: begin
                    if (fall) begin
                        ctx_nx.cnt = '0;
                        if (ctx.cnt < WIN_LO) begin
                            ctx_nx.state = WD_FAULT;
                        end
                    end else if (ctx.cnt == WIN_LAST) begin
                        ctx_nx.state = WD_FAULT;
                        ctx_nx.cnt   = '0;
                    end else begin
                        ctx_nx.cnt = ctx.cnt + 1'b1;
                    end
                end
                WD_FAULT: begin
                    if (ctx.cnt == RST_LAST) begin
                        ctx_nx.state = WD_DELAY;
                        ctx_nx.cnt   = '0;
                    end else begin
                        ctx_nx.cnt = ctx.cnt + 1'b1;
                    end
                end
                default: begin
                    ctx_nx.state = WD_IDLE;
                    ctx_nx.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.state <= WD_IDLE;
            ctx.cnt   <= '0;
        end else begin
            ctx <= ctx_nx;
        end
    end

    assign fault_n = (ctx.state != WD_FAULT);
endmodule

// File: rtl/dual_rail_supervisor.sv
module dual_rail_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned RESET_CYCLES = 20,
    parameter int unsigned DELAY_CYCLES = 15,
    parameter int unsigned WIN_MIN      = 8,
    parameter int unsigned WIN_MAX      = 30,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned NUM_RAILS    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic rail_a_good,
    input  logic rail_b_good,
    input  logic wd_in,
    output logic rst_a_n,
    output logic rst_b_n,
    output logic wd_fault_n
);
    localparam int unsigned LONGEST =
        max2(max2(RESET_CYCLES, DELAY_CYCLES), WIN_MAX);
    localparam int unsigned CW = cnt_bits(LONGEST);

    logic [NUM_RAILS-1:0] good_vec;
    logic [NUM_RAILS-1:0] rel_vec;
    logic                 wd_fall;

    assign good_vec = {rail_b_good, rail_a_good};

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        sup_rail_timer #(
            .RESET_CYCLES(RESET_CYCLES),
            .CW          (CW)
        ) u_timer (
            .clk     (clk),
            .rst     (rst),
            .qualify (enable & good_vec[g]),
            .released(rel_vec[g])
        );
    end

    sup_edge_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (wd_in),
        .fall(wd_fall)
    );

    sup_watchdog #(
        .RESET_CYCLES(RESET_CYCLES),
        .DELAY_CYCLES(DELAY_CYCLES),
        .WIN_MIN     (WIN_MIN),
        .WIN_MAX     (WIN_MAX),
        .CW          (CW)
    ) u_wd (
        .clk      (clk),
        .rst      (rst),
        .supervise(&rel_vec),
        .fall     (wd_fall),
        .fault_n  (wd_fault_n)
    );

    assign rst_a_n = rel_vec[0];
    assign rst_b_n = rel_vec[1];
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
    parameter int unsigned RESET_CYCLES = 20
) (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic rail_a_good,
    input logic rail_b_good,
    input logic rst_a_n,
    input logic rst_b_n,
    input logic wd_fault_n
);
    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (rst || wd_fault_n) begin
            low_run <= 0;
        end else begin
            low_run <= low_run + 1;
        end
    end

    AST_A_DROP: assert property (@(posedge clk) disable iff (rst)
        (!enable || !rail_a_good) |=> !rst_a_n); // R10
    AST_B_DROP: assert property (@(posedge clk) disable iff (rst)
        (!enable || !rail_b_good) |=> !rst_b_n); // R10
    AST_A_RELEASE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_a_n) |-> ($past(enable) && $past(rail_a_good))); // R2
    AST_B_RELEASE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_b_n) |-> ($past(enable) && $past(rail_b_good))); // R3
    AST_WD_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        (!rst_a_n || !rst_b_n) |=> wd_fault_n); // R10
    AST_FAULT_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_fault_n) |-> ($past(rst_a_n) && $past(rst_b_n))); // R4
    AST_FAULT_LENGTH: assert property (@(posedge clk) disable iff (rst)
        !wd_fault_n |-> (low_run < RESET_CYCLES)); // R9
endmodule

bind dual_rail_supervisor sup_checker #(
    .RESET_CYCLES(RESET_CYCLES)
) u_sup_checker (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .rail_a_good(rail_a_good),
    .rail_b_good(rail_b_good),
    .rst_a_n    (rst_a_n),
    .rst_b_n    (rst_b_n),
    .wd_fault_n (wd_fault_n)
);

// File: tb/dual_rail_supervisor_tb.sv
module dual_rail_supervisor_tb;
    localparam int RST_C = 20;
    localparam int DLY_C = 15;
    localparam int WMIN  = 8;
    localparam int WMAX  = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic rail_a_good = 1'b0;
    logic rail_b_good = 1'b0;
    logic wd_in = 1'b1;
    logic rst_a_n, rst_b_n, wd_fault_n;

    always #10 clk = ~clk;

    dual_rail_supervisor #(
        .RESET_CYCLES(RST_C),
        .DELAY_CYCLES(DLY_C),
        .WIN_MIN     (WMIN),
        .WIN_MAX     (WMAX)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .rail_a_good(rail_a_good),
        .rail_b_good(rail_b_good),
        .wd_in      (wd_in),
        .rst_a_n    (rst_a_n),
        .rst_b_n    (rst_b_n),
        .wd_fault_n (wd_fault_n)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string tag = "R1";
    bit    running = 1'b0;
    bit    finished = 1'b0;

    // reference model: 0 idle, 1 delay, 2 window, 3 fault
    int ga = 0, gb = 0, m_mode = 0, m_t = 0;
    bit m_rel_a = 1'b0, m_rel_b = 1'b0;
    bit wq[$];

    always @(posedge clk) begin
        if (rst) begin
            ga = 0; gb = 0; m_mode = 0; m_t = 0;
            m_rel_a = 1'b0; m_rel_b = 1'b0;
            wq = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit fall_seen;
            bit both;
            fall_seen = wq[2] && !wq[1];
            both = m_rel_a && m_rel_b;
            if (!both) begin
                m_mode = 0; m_t = 0;
            end else if (m_mode == 0) begin
                m_mode = 1; m_t = 0;
            end else if (m_mode == 1) begin
                m_t++;
                if (m_t == DLY_C) begin m_mode = 2; m_t = 0; end
            end else if (m_mode == 2) begin
                if (fall_seen) begin
                    if (m_t < WMIN) m_mode = 3;
                    m_t = 0;
                end else begin
                    m_t++;
                    if (m_t == WMAX) begin m_mode = 3; m_t = 0; end
                end
            end else begin
                m_t++;
                if (m_t == RST_C) begin m_mode = 1; m_t = 0; end
            end
            ga = (enable && rail_a_good) ? ((ga < RST_C) ? ga + 1 : ga) : 0;
            gb = (enable && rail_b_good) ? ((gb < RST_C) ? gb + 1 : gb) : 0;
            m_rel_a = (ga >= RST_C);
            m_rel_b = (gb >= RST_C);
            wq.push_front(wd_in);
            while (wq.size() > 3) void'(wq.pop_back());
        end
    end

    task automatic chk(input bit act, input bit exp, input string req, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (running && !finished) begin
            chk(rst_a_n, m_rel_a, (tag == "R1") ? "R1" : "R2", "rst_a_n");
            chk(rst_b_n, m_rel_b, (tag == "R1") ? "R1" : "R3", "rst_b_n");
            chk(wd_fault_n, (m_mode != 3), tag, "wd_fault_n");
        end
    end

    task automatic pulse();
        wd_in = 1'b0;
        repeat (4) @(negedge clk);
        wd_in = 1'b1;
    endtask

    task automatic wait_mode(input int m);
        for (int i = 0; i < 400 && m_mode != m; i++) @(negedge clk);
        if (m_mode != m) begin
            n_cmp++; n_bad++;
            $display("FAIL %s wait for phase: actual %0d expected %0d", tag, m_mode, m);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        running = 1'b1;
        repeat (3) @(negedge clk);
        tag = "R1";
        chk(rst_a_n, 1'b0, "R1", "rst_a_n after reset");
        chk(wd_fault_n, 1'b1, "R1", "wd_fault_n after reset");

        // staggered rail bring-up
        tag = "R11";
        enable = 1'b1;
        rail_a_good = 1'b1;
        repeat (7) @(negedge clk);
        rail_b_good = 1'b1;
        repeat (RST_C - 7) @(negedge clk);
        chk(rst_a_n, 1'b1, "R2", "rail A released");
        chk(rst_b_n, 1'b0, "R3", "rail B still held");
        repeat (7) @(negedge clk);
        chk(rst_b_n, 1'b1, "R3", "rail B released");

        // activity during the start-up delay is ignored
        tag = "R4";
        wait_mode(1);
        pulse();
        repeat (3) @(negedge clk);
        chk(wd_fault_n, 1'b1, "R4", "delay ignores kick");

        // steady kicks inside the window; rising edges ignored
        tag = "R8";
        wait_mode(2);
        for (int k = 0; k < 6; k++) begin
            repeat (12) @(negedge clk);
            pulse();
        end
        chk(wd_fault_n, 1'b1, "R5", "in-window kicks accepted");

        // early kick
        tag = "R6";
        repeat (4) @(negedge clk);
        pulse();
        repeat (2) @(negedge clk);
        chk(wd_fault_n, 1'b0, "R6", "early kick faults");
        tag = "R9";
        wait_mode(1);
        chk(wd_fault_n, 1'b1, "R9", "fault released after timeout");

        // missing kick
        tag = "R7";
        wait_mode(2);
        wait_mode(3);
        chk(wd_fault_n, 1'b0, "R7", "late fault");
        tag = "R9";
        wait_mode(2);
        repeat (10) @(negedge clk);
        pulse();

        // rail drop mid-window
        tag = "R10";
        repeat (5) @(negedge clk);
        rail_b_good = 1'b0;
        repeat (2) @(negedge clk);
        chk(rst_b_n, 1'b0, "R10", "rail B drop");
        chk(wd_fault_n, 1'b1, "R10", "watchdog idle on drop");
        repeat (5) @(negedge clk);
        rail_b_good = 1'b1;
        wait_mode(2);
        repeat (10) @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        chk(rst_a_n, 1'b0, "R10", "enable low rail A");
        chk(rst_b_n, 1'b0, "R10", "enable low rail B");
        repeat (5) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule